// File: doc/BRIEF.md
# Gated timer counter

A single timer channel for a microcontroller-style subsystem. The count step comes from one of two places: a clock enable that divides the bus clock by a power of two from 1 to 128, or rising edges on an external event pin. The divided clock is a one-cycle enable pulse and never a derived clock, so every flop runs on the bus clock. The external event pin passes through a two-flop synchronizer before its edges are detected.

A level on the gate input can allow or block counting, with either polarity. When a gated mode is selected, the clock select still sets the counting rate. The counter runs up or down and is 16 or 32 bits wide. At terminal count it either reloads and keeps running, or it stops and waits for software to clear and then set the enable.

At terminal count the block can also set a sticky interrupt flag, which a dedicated clear input resets. Software drives the control word and the reload value directly as inputs.

Top module: `gated_timer`

## Requirements
- R1: Clock select codes 0001 to 1000 give one count step every 1, 2, 4, 8, 16, 32, 64 and 128 bus cycles. Codes 0000 and 1001 to 1110 behave like 0001. The divider phase starts again at enable, so the first step lands on the N-th enabled clock edge.
- R2: Clock select 1111 makes each rising edge of `ext_event` count exactly once, however long the pulse is. The count changes on the third rising clock edge after the input rises.
- R3: Mode 01 counts only on steps where `ext_gate` is low at the clock edge. Mode 10 counts only where it is high. In both modes the clock select still sets the step rate, and an external event source is gated in the same way.
- R4: Modes 00 and 11 ignore `ext_gate`.
- R5: With `cfg_down`=0 the counter runs up from 0 toward the reload value. With `cfg_down`=1 it runs down from the reload value toward 0.
- R6: With `cfg_wide`=0 the counter is 16 bits wide. `reload_val[31:16]` is ignored and `count[31:16]` reads 0. With `cfg_wide`=1 all 32 bits take part, and borrows and carries cross bit 16.
- R7: With `cfg_reload_en`=1, a step that reaches the terminal value (the reload value going up, 0 going down) loads the start value on that same edge and counting goes on.
- R8: With `cfg_reload_en`=0, a step that reaches the terminal value leaves it in `count`, and the counter holds it for as long as `cfg_enable` stays 1.
- R9: While `cfg_enable`=0, `count` takes the start value (0 going up, the masked reload value going down) on the next edge and the halt is cleared. Setting the enable again restarts counting.
- R10: `irq` is set at terminal count when `cfg_irq_en`=1 and is never set when it is 0. `irq_clear` resets it on the next edge. A terminal count in the same cycle wins over the clear.
- R11: After reset, `count` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_sel | input | 4 | Count source and bus clock divider select |
| cfg_mode | input | 2 | 00 free, 01 gate-low, 10 gate-high, 11 treated as free |
| cfg_irq_en | input | 1 | Allow terminal count to set the interrupt flag |
| cfg_down | input | 1 | 0 up, 1 down |
| cfg_wide | input | 1 | 0 16-bit, 1 32-bit |
| cfg_reload_en | input | 1 | 1 reload at terminal count, 0 halt |
| cfg_enable | input | 1 | Run enable; low loads the start value |
| reload_val | input | 32 | Reload / terminal value |
| ext_event | input | 1 | Asynchronous external event pin |
| ext_gate | input | 1 | Synchronous gate level |
| irq_clear | input | 1 | Clears the interrupt flag |
| count | output | 32 | Current count |
| irq | output | 1 | Sticky terminal-count interrupt flag |

## Verification
The bench uses the default parameters: a 32-bit counter with a 16-bit narrow width and a 7-bit divider phase. With these values every divider setting up to 128 can be swept in full through reload and halt, in both directions, using a small reload value of 3. They also keep a complete 16-bit wrap (65536 steps) inside the run time. Expected counts come from closed-form expressions in the number of elapsed edges. The 32-bit width is checked with a borrow across bit 16 rather than a full wrap.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'b00,
        MODE_GATE_LO = 2'b01,
        MODE_GATE_HI = 2'b10,
        MODE_CHAIN   = 2'b11
    } gtmr_mode_e;

    localparam logic [3:0] SEL_EXT_EVENT = 4'b1111;

    // Divider exponent for a clock select code; unused codes map to 0.
    function automatic logic [2:0] sel_to_shift(input logic [3:0] sel);
        logic [2:0] sh;
        sh = 3'd0;
        if (sel >= 4'd1 && sel <= 4'd8) begin
            sh = 3'(sel - 4'd1);
        end
        return sh;
    endfunction

endpackage

// File: rtl/gtmr_prescaler.sv
module gtmr_prescaler #(
    parameter int PRESC_W = 7,
    localparam int SHIFT_W = $clog2(PRESC_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    typedef struct packed {
        logic [PRESC_W-1:0] phase;
    } presc_st_t;

    presc_st_t st_d, st_q;
    logic [PRESC_W:0]   span;
    logic [PRESC_W-1:0] mask;

    always_comb begin
        span     = (PRESC_W + 1)'(1) << shift;
        mask     = span[PRESC_W-1:0] - PRESC_W'(1);
        tick     = run && ((st_q.phase & mask) == mask);
        st_d     = st_q;
        st_d.phase = run ? st_q.phase + PRESC_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gtmr_edge_sync.sv
module gtmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.last = st_q.sync[STAGES-1];
        rise      = st_q.sync[STAGES-1] & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             step,
    input  logic             down,
    input  logic             wide,
    input  logic             reload_en,
    input  logic             irq_en,
    input  logic             irq_clear,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             halted
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
        logic             halted;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] width_mask;
    logic [CNT_W-1:0] reload_m;
    logic [CNT_W-1:0] start_v;
    logic [CNT_W-1:0] term_v;
    logic [CNT_W-1:0] stepped;
    logic             term_hit;

    always_comb begin
        width_mask = wide ? {CNT_W{1'b1}}
                          : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        reload_m   = reload_val & width_mask;
        start_v    = down ? reload_m : '0;
        term_v     = down ? '0 : reload_m;
        stepped    = (down ? st_q.count - CNT_W'(1) : st_q.count + CNT_W'(1)) & width_mask;
        term_hit   = 1'b0;
        st_d       = st_q;

        if (!enable) begin
            st_d.count  = start_v;
            st_d.halted = 1'b0;
        end else if (step && !st_q.halted) begin
            if (stepped == term_v) begin
                term_hit = 1'b1;
                if (reload_en) begin
                    st_d.count = start_v;
                end else begin
                    st_d.count  = stepped;
                    st_d.halted = 1'b1;
                end
            end else begin
                st_d.count = stepped;
            end
        end

        st_d.count = st_d.count & width_mask;

        if (irq_clear) begin
            st_d.irq = 1'b0;
        end
        if (term_hit && irq_en) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.count;
    assign irq    = st_q.irq;
    assign halted = st_q.halted;

endmodule

// File: rtl/gated_timer.sv
module gated_timer #(
    parameter int CNT_W       = 32,
    parameter int NARROW_W    = 16,
    parameter int PRESC_W     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_clk_sel,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_irq_en,
    input  logic             cfg_down,
    input  logic             cfg_wide,
    input  logic             cfg_reload_en,
    input  logic             cfg_enable,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             ext_event,
    input  logic             ext_gate,
    input  logic             irq_clear,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    import gtmr_pkg::*;

    localparam int SHIFT_W = $clog2(PRESC_W + 1);

    logic [SHIFT_W-1:0] presc_shift;
    logic               presc_tick;
    logic               evt_rise;
    logic               use_ext;
    logic               gate_ok;
    logic               step;
    logic               core_halted;

    always_comb begin
        presc_shift = SHIFT_W'(sel_to_shift(cfg_clk_sel));
        use_ext     = (cfg_clk_sel == SEL_EXT_EVENT);
        case (gtmr_mode_e'(cfg_mode))
            MODE_GATE_LO: gate_ok = ~ext_gate;
            MODE_GATE_HI: gate_ok = ext_gate;
            default:      gate_ok = 1'b1;
        endcase
        step = (use_ext ? evt_rise : presc_tick) & gate_ok;
    end

    gtmr_prescaler #(
        .PRESC_W (PRESC_W)
    ) i_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_enable),
        .shift (presc_shift),
        .tick  (presc_tick)
    );

    gtmr_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_event_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_event),
        .rise  (evt_rise)
    );

    gtmr_counter #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W)
    ) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .step       (step),
        .down       (cfg_down),
        .wide       (cfg_wide),
        .reload_en  (cfg_reload_en),
        .irq_en     (cfg_irq_en),
        .irq_clear  (irq_clear),
        .reload_val (reload_val),
        .count      (count),
        .irq        (irq),
        .halted     (core_halted)
    );

endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_down,
    input logic             cfg_wide,
    input logic             cfg_irq_en,
    input logic             irq_clear,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             halted
);

    // R6
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wide |=> count[CNT_W-1:NARROW_W] == '0);

    // R9
    idle_start_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !cfg_down) |=> count == '0);

    // R9
    idle_start_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && cfg_down && cfg_wide) |=> count == $past(reload_val));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && cfg_enable && (cfg_wide || count[CNT_W-1:NARROW_W] == '0))
        |=> ($stable(count) && halted));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_irq_en && !irq) |=> !irq);

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !cfg_irq_en) |=> !irq);

endmodule

bind gated_timer gtmr_chk #(
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_down   (cfg_down),
    .cfg_wide   (cfg_wide),
    .cfg_irq_en (cfg_irq_en),
    .irq_clear  (irq_clear),
    .reload_val (reload_val),
    .count      (count),
    .irq        (irq),
    .halted     (core_halted)
);

// File: tb/test_gated_timer.sv
`timescale 1ns/1ps
module test_gated_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_clk_sel = 4'd0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_down = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_reload_en = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [31:0] reload_val = 32'd0;
    logic        ext_event = 1'b0;
    logic        ext_gate = 1'b0;
    logic        irq_clear = 1'b0;
    logic [31:0] count;
    logic        irq;

    int n_vec = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    gated_timer i_gated_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_clk_sel   (cfg_clk_sel),
        .cfg_mode      (cfg_mode),
        .cfg_irq_en    (cfg_irq_en),
        .cfg_down      (cfg_down),
        .cfg_wide      (cfg_wide),
        .cfg_reload_en (cfg_reload_en),
        .cfg_enable    (cfg_enable),
        .reload_val    (reload_val),
        .ext_event     (ext_event),
        .ext_gate      (ext_gate),
        .irq_clear     (irq_clear),
        .count         (count),
        .irq           (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int div_of(input int sel);
        if (sel >= 1 && sel <= 8) return 1 << (sel - 1);
        return 1;
    endfunction

    function automatic logic gate_pat(input int i);
        return logic'(((i / 3) % 2) == 1) ^ logic'((i % 5) == 0);
    endfunction

    // Disable, load configuration and clear the flag; count must show the start value.
    task automatic setup(input logic [3:0] sel, input logic [1:0] mode, input logic dn,
                         input logic rel, input logic ien, input logic wd, input logic [31:0] rv);
        @(negedge clk);
        cfg_enable = 1'b0; cfg_clk_sel = sel; cfg_mode = mode; cfg_down = dn;
        cfg_reload_en = rel; cfg_irq_en = ien; cfg_wide = wd; reload_val = rv;
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    // R1 R5 R7 R8 R10 sweep: closed-form count from elapsed edges.
    task automatic run_sweep(input int sel, input logic [1:0] mode, input logic dn,
                             input logic rel, input logic ien, input int rv);
        int n;
        int t;
        int m;
        int ec;
        int tcs;
        n = div_of(sel);
        setup(4'(sel), mode, dn, rel, ien, 1'b0, 32'(rv));
        check("R9 start value", count, dn ? 32'(rv) : 32'd0);
        check("R10 cleared", {31'd0, irq}, 32'd0);
        cfg_enable = 1'b1;
        for (int j = 1; j <= n * (rv + 2); j++) begin
            @(negedge clk);
            t = j / n;
            if (rel) begin
                m   = t % rv;
                ec  = dn ? ((m == 0) ? rv : rv - m) : m;
                tcs = t / rv;
            end else begin
                ec  = dn ? ((t < rv) ? rv - t : 0) : ((t < rv) ? t : rv);
                tcs = (t >= rv) ? 1 : 0;
            end
            check(rel ? "R1 R4 R5 R7 count" : "R1 R4 R5 R8 count", count, 32'(ec));
            check("R10 flag", {31'd0, irq}, (ien && tcs > 0) ? 32'd1 : 32'd0);
            ext_gate = ~ext_gate;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        int ecnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        check("R11 reset count", count, 32'd0);
        check("R11 reset irq", {31'd0, irq}, 32'd0);

        // Every clock select except external, both directions, reload and halt.
        for (int sel = 0; sel < 15; sel++) begin
            for (int k = 0; k < 4; k++) begin
                run_sweep(sel, 2'b00, logic'(k[0]), logic'(k[1]), logic'(k[0] ^ k[1]), 3);
            end
        end
        // R4: mode 11 behaves as the free mode, gate toggling
        run_sweep(2, 2'b11, 1'b0, 1'b1, 1'b1, 3);
        run_sweep(4, 2'b11, 1'b1, 1'b0, 1'b1, 3);

        // R3: gated modes at divide-by-2
        for (int gm = 1; gm <= 2; gm++) begin
            setup(4'd2, 2'(gm), 1'b0, 1'b1, 1'b0, 1'b0, 32'd1000);
            ecnt = 0;
            ext_gate = gate_pat(0);
            cfg_enable = 1'b1;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if ((i % 2 == 1) && ((gm == 1) ? !gate_pat(i) : gate_pat(i))) ecnt++;
                check("R3 gated count", count, 32'(ecnt));
                ext_gate = gate_pat(i + 1);
            end
        end

        // R2: external events, one count per rising edge
        ext_event = 1'b0;
        ext_gate  = 1'b0;
        setup(4'hF, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 32'd1000);
        repeat (3) @(negedge clk);
        cfg_enable = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            ext_event = 1'b1;
            repeat (1 + (k % 3)) @(negedge clk);
            ext_event = 1'b0;
            repeat (4) @(negedge clk);
            check("R2 event count", count, 32'(k));
        end
        // R3: event source blocked by gate-high mode with gate low
        cfg_mode = 2'b10;
        for (int k = 0; k < 3; k++) begin
            ext_event = 1'b1;
            @(negedge clk);
            ext_event = 1'b0;
            repeat (4) @(negedge clk);
        end
        check("R3 gated events blocked", count, 32'd6);
        ext_gate  = 1'b1;
        ext_event = 1'b1;
        @(negedge clk);
        ext_event = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 gated event passed", count, 32'd7);

        // R6: 32-bit borrow across bit 16, then narrow truncation
        setup(4'd1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0001_0001);
        check("R6 wide start", count, 32'h0001_0001);
        cfg_enable = 1'b1;
        @(negedge clk);
        check("R6 wide step", count, 32'h0001_0000);
        @(negedge clk);
        check("R6 wide borrow", count, 32'h0000_FFFF);
        cfg_enable = 1'b0;
        cfg_wide   = 1'b0;
        @(negedge clk);
        check("R6 narrow start", count, 32'h0000_0001);
        cfg_enable = 1'b1;
        @(negedge clk);
        check("R6 R8 narrow terminal", count, 32'd0);
        check("R10 narrow flag", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        check("R8 narrow hold", count, 32'd0);

        // R6 R7: full 16-bit wrap with reload value 0
        setup(4'd1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0005_0000);
        cfg_enable = 1'b1;
        for (int j = 1; j <= 65536; j++) begin
            @(negedge clk);
            if (j % 8192 == 0 || j == 65535) begin
                check("R6 R7 narrow wrap count", count, 32'(j % 65536));
                check("R10 wrap flag", {31'd0, irq}, (j == 65536) ? 32'd1 : 32'd0);
            end
        end

        // R8 R9 R10: halt, restart by disable/enable, flag clear
        setup(4'd1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 32'd3);
        cfg_enable = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 halted", count, 32'd3);
        check("R10 halt flag", {31'd0, irq}, 32'd1);
        cfg_enable = 1'b0;
        @(negedge clk);
        check("R9 reloaded", count, 32'd0);
        cfg_enable = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 restarted", count, 32'd2);
        repeat (3) @(negedge clk);
        check("R8 halted again", count, 32'd3);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check("R10 cleared", {31'd0, irq}, 32'd0);
        repeat (3) @(negedge clk);
        check("R10 stays clear", {31'd0, irq}, 32'd0);
        check("R8 still held", count, 32'd3);

        // R10: set wins over a held clear
        setup(4'd1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 32'd2);
        irq_clear  = 1'b1;
        cfg_enable = 1'b1;
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            check("R7 short period", count, 32'(j % 2));
            check("R10 set beats clear", {31'd0, irq}, (j % 2 == 0) ? 32'd1 : 32'd0);
        end
        irq_clear = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule